// File: doc/BRIEF.md
# Tail-Biting Cyclic Extension Buffer

This block sits in front of a wrap-around Viterbi decoder for a rate-1/3, tail-biting convolutional code. It takes in one framed message of three-lane code samples, qualified by start, end and valid strobes, and writes it into on-chip storage. Once the frame closes, the block plays the whole message back. It then appends a wrap-around tail of 80 more samples (twice a training depth of 40), which start again from message sample 0. The decoder can use this tail to settle its state metrics for a code whose encoder starts and ends in the same state.

Each replayed sample carries three tags: its trellis step index, a flag that separates payload positions from training positions, and a last flag on the final tail sample. A busy output tells the upstream source when a new frame may be sent. Two error pulses report a frame that exceeds the configured maximum and a start that arrives while a replay is still running. The storage depth is the configured maximum rounded up to a power of two. Soft inputs are signed words of 1 to 15 bits. A width of 1 carries hard decisions.

Top module: `wava_ext_buf`

## Requirements
- R1: Lane k of a sample (k = 0, 1, 2 for the first, second and third generator polynomial) occupies bits `in_data_i[k*SOFT_W +: SOFT_W]` and keeps that position on `out_data_o`. Replay steps 0 to M-1 return stored samples 0 to M-1 in arrival order, with `out_train_o` low.
- R2: Replay steps M to M+79 return stored sample (s-M) mod M, with `out_train_o` high. This also holds when M is less than 80.
- R3: A replay is a run of exactly M+80 cycles with `out_valid_o` high and no gaps. `out_step_o` counts 0, 1, 2, ... through the run.
- R4: `out_last_o` is high on step M+79 only. `out_valid_o` is low in the cycle after it.
- R5: The first replay sample (step 0) appears right after the second rising edge that follows the edge sampling the end-of-frame sample.
- R6: `busy_o` goes high right after the edge that accepts the frame end. It stays high through step M+78 and is low from the cycle in which `out_last_o` is high.
- R7: A valid start while `busy_o` is high writes nothing and leaves the running replay unchanged. It does not lead to another replay, and `err_start_o` pulses for one cycle after that edge.
- R8: The first valid sample beyond MAX_LEN within one frame makes `err_len_o` pulse for one cycle after that edge. That frame is then dropped: no replay follows and `busy_o` stays low. The next frame is handled normally.
- R9: Samples with `in_valid_i` low are not stored, even when start or end is high. Valid samples outside a frame (no start seen) are ignored.
- R10: A frame of exactly MAX_LEN samples is accepted and replayed in full.
- R11: A valid start arriving while a frame is still being filled drops the partial frame and begins a new frame at sample 0.
- R12: Right after reset, `out_valid_o`, `out_last_o`, `busy_o`, `err_len_o` and `err_start_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 3*SOFT_W | Three-lane code sample, lane 0 in the low bits |
| in_start_i | input | 1 | First sample of a frame |
| in_end_i | input | 1 | Last sample of a frame |
| in_valid_i | input | 1 | Input sample qualifier |
| busy_o | output | 1 | Replay pending or running; new frames are not accepted |
| err_len_o | output | 1 | One-cycle pulse: frame longer than MAX_LEN |
| err_start_o | output | 1 | One-cycle pulse: start rejected during replay |
| out_data_o | output | 3*SOFT_W | Replayed sample |
| out_valid_o | output | 1 | Replay sample qualifier |
| out_step_o | output | clog2(MAX_LEN+80) | Trellis step index of the replayed sample |
| out_train_o | output | 1 | Sample belongs to the wrap-around training tail |
| out_last_o | output | 1 | Final sample of the replay |

## Verification
The frame lengths tested sit around the 80-sample tail. With M = 6 the tail wraps many times, while 79, 80 and 81 put the wrap point just before, exactly at and just after the tail end. A design that wrapped at the storage depth instead of at M, or that stopped at 80 regardless of M, would return the wrong sample on the first mismatching step. Frames of MAX_LEN and MAX_LEN+1 check the overflow boundary: an off-by-one there either drops a legal frame or replays corrupted data without an error pulse. Gapped input, starts during a running replay and restarted partial frames check that nothing outside a clean, valid frame reaches storage or changes the sequence already running.

// File: rtl/ext_buf_pkg.sv
package ext_buf_pkg;
  localparam int unsigned NUM_LANES   = 3;
  localparam int unsigned TRAIN_T     = 40;
  localparam int unsigned EXT_SAMPLES = 2 * TRAIN_T;
endpackage

// File: rtl/ext_buf_capture.sv
module ext_buf_capture #(
  parameter int unsigned MAX_LEN = 100,
  parameter int unsigned LEN_W   = 7,
  parameter int unsigned AW      = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             end_i,
  input  logic             valid_i,
  input  logic             busy_i,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic             launch_o,
  output logic [LEN_W-1:0] len_o,
  output logic             err_len_o,
  output logic             err_start_o
);
  logic             fill_q;
  logic             ovf_q;
  logic [LEN_W-1:0] count_q;
  logic             full;

  assign full      = (count_q == LEN_W'(MAX_LEN));
  assign wr_en_o   = valid_i && ((start_i && !busy_i) || (!start_i && fill_q && !full));
  assign wr_addr_o = start_i ? '0 : count_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q      <= 1'b0;
      ovf_q       <= 1'b0;
      count_q     <= '0;
      launch_o    <= 1'b0;
      len_o       <= '0;
      err_len_o   <= 1'b0;
      err_start_o <= 1'b0;
    end else begin
      launch_o    <= 1'b0;
      err_len_o   <= 1'b0;
      err_start_o <= 1'b0;
      if (valid_i && start_i) begin
        if (busy_i) begin
          err_start_o <= 1'b1;
        end else begin
          ovf_q   <= 1'b0;
          count_q <= LEN_W'(1);
          if (end_i) begin
            fill_q   <= 1'b0;
            launch_o <= 1'b1;
            len_o    <= LEN_W'(1);
          end else begin
            fill_q <= 1'b1;
          end
        end
      end else if (valid_i && fill_q) begin
        if (full) begin
          ovf_q <= 1'b1;
          if (!ovf_q) err_len_o <= 1'b1;
        end else begin
          count_q <= count_q + LEN_W'(1);
        end
        if (end_i) begin
          fill_q <= 1'b0;
          if (!full) begin
            launch_o <= 1'b1;
            len_o    <= count_q + LEN_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/ext_buf_ram.sv
module ext_buf_ram #(
  parameter int unsigned W     = 4,
  parameter int unsigned LANES = 3,
  parameter int unsigned AW    = 7,
  parameter int unsigned DEPTH = 128
) (
  input  logic               clk_i,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [LANES*W-1:0] wr_data_i,
  input  logic               rd_en_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic [LANES*W-1:0] rd_data_o
);
  // one storage array per code lane
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (wr_en_i) mem[wr_addr_i] <= wr_data_i[k*W +: W];
      if (rd_en_i) rd_data_o[k*W +: W] <= mem[rd_addr_i];
    end
  end
endmodule

// File: rtl/ext_buf_replay.sv
module ext_buf_replay #(
  parameter int unsigned LEN_W  = 7,
  parameter int unsigned AW     = 7,
  parameter int unsigned STEP_W = 8,
  parameter int unsigned EXT    = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              rd_en_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic              active_o,
  output logic              vld_o,
  output logic [STEP_W-1:0] step_o,
  output logic              train_o,
  output logic              last_o
);
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  ptr_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] last_step;
  logic              at_last;

  assign last_step = STEP_W'(len_q) + STEP_W'(EXT - 1);
  assign at_last   = (step_q == last_step);
  assign rd_en_o   = active_o;
  assign rd_addr_o = ptr_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      len_q    <= '0;
      ptr_q    <= '0;
      step_q   <= '0;
    end else if (launch_i) begin
      active_o <= 1'b1;
      len_q    <= len_i;
      ptr_q    <= '0;
      step_q   <= '0;
    end else if (active_o) begin
      step_q <= step_q + STEP_W'(1);
      // address wraps at the message length, covering payload and tail alike
      ptr_q  <= (ptr_q == len_q - LEN_W'(1)) ? '0 : ptr_q + LEN_W'(1);
      if (at_last) active_o <= 1'b0;
    end
  end

  // tags aligned with the registered read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      step_o  <= '0;
      train_o <= 1'b0;
      last_o  <= 1'b0;
    end else begin
      vld_o   <= active_o;
      step_o  <= step_q;
      train_o <= active_o && (step_q >= STEP_W'(len_q));
      last_o  <= active_o && at_last;
    end
  end

  AST_STEP_INCR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && $past(vld_o) |-> step_o == $past(step_o) + STEP_W'(1)); // R3
  AST_TRAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && $past(vld_o) && $past(train_o) |-> train_o); // R2
  AST_LAST_TRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> vld_o && train_o); // R4
  AST_LAST_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !vld_o); // R4
endmodule

// File: rtl/wava_ext_buf.sv
module wava_ext_buf
  import ext_buf_pkg::*;
#(
  parameter int unsigned MAX_LEN = 100,
  parameter int unsigned SOFT_W  = 4
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic [NUM_LANES*SOFT_W-1:0]                   in_data_i,
  input  logic                                          in_start_i,
  input  logic                                          in_end_i,
  input  logic                                          in_valid_i,
  output logic                                          busy_o,
  output logic                                          err_len_o,
  output logic                                          err_start_o,
  output logic [NUM_LANES*SOFT_W-1:0]                   out_data_o,
  output logic                                          out_valid_o,
  output logic [$clog2(MAX_LEN+EXT_SAMPLES)-1:0]        out_step_o,
  output logic                                          out_train_o,
  output logic                                          out_last_o
);
  localparam int unsigned AW     = $clog2(MAX_LEN);
  localparam int unsigned DEPTH  = 1 << AW;
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1);
  localparam int unsigned STEP_W = $clog2(MAX_LEN + EXT_SAMPLES);
  localparam int unsigned DW     = NUM_LANES * SOFT_W;

  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic             launch;
  logic [LEN_W-1:0] len;
  logic             rd_en;
  logic [AW-1:0]    rd_addr;
  logic             active;

  assign busy_o = launch | active;

  ext_buf_capture #(
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W),
    .AW      (AW)
  ) u_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (in_start_i),
    .end_i       (in_end_i),
    .valid_i     (in_valid_i),
    .busy_i      (busy_o),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .launch_o    (launch),
    .len_o       (len),
    .err_len_o   (err_len_o),
    .err_start_o (err_start_o)
  );

  ext_buf_ram #(
    .W     (SOFT_W),
    .LANES (NUM_LANES),
    .AW    (AW),
    .DEPTH (DEPTH)
  ) u_ram (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (in_data_i),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rd_data_o (out_data_o)
  );

  ext_buf_replay #(
    .LEN_W  (LEN_W),
    .AW     (AW),
    .STEP_W (STEP_W),
    .EXT    (EXT_SAMPLES)
  ) u_replay (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .len_i     (len),
    .rd_en_o   (rd_en),
    .rd_addr_o (rd_addr),
    .active_o  (active),
    .vld_o     (out_valid_o),
    .step_o    (out_step_o),
    .train_o   (out_train_o),
    .last_o    (out_last_o)
  );

  AST_WR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> !busy_o); // R7
  AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_len_o, err_start_o})); // R8
  AST_BUSY_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> !busy_o); // R6
  AST_LAUNCH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> busy_o && !out_valid_o); // R5
  AST_LEN_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_len_o |-> !busy_o); // R8

  if (DW == 0) begin : g_bad_width
    initial $display("wava_ext_buf: zero data width");
  end
endmodule

// File: tb/wava_ext_buf_tb.sv
module wava_ext_buf_tb_top;
  localparam int MAX_LEN = 100;
  localparam int SW      = 4;
  localparam int DW      = 3 * SW;
  localparam int STW     = $clog2(MAX_LEN + 80);
  localparam int NVEC    = 7;
  // {length, data seed, insert gaps}
  localparam int VEC [NVEC][3] = '{
    '{6, 1, 0}, '{40, 2, 1}, '{79, 3, 0}, '{80, 4, 0},
    '{81, 5, 1}, '{100, 6, 0}, '{13, 7, 1}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [DW-1:0]  in_data = '0;
  logic           in_start = 1'b0, in_end = 1'b0, in_valid = 1'b0;
  logic           busy, err_len, err_start, out_valid, out_train, out_last;
  logic [DW-1:0]  out_data;
  logic [STW-1:0] out_step;
  int             n_chk = 0, n_fail = 0;
  bit             done = 1'b0;

  always #10 clk = ~clk;

  wava_ext_buf #(.MAX_LEN(MAX_LEN), .SOFT_W(SW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_data_i(in_data), .in_start_i(in_start),
    .in_end_i(in_end), .in_valid_i(in_valid), .busy_o(busy), .err_len_o(err_len),
    .err_start_o(err_start), .out_data_o(out_data), .out_valid_o(out_valid),
    .out_step_o(out_step), .out_train_o(out_train), .out_last_o(out_last)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] smp(input int seed, input int i);
    logic [DW-1:0] v;
    for (int k = 0; k < 3; k++) v[k*SW +: SW] = SW'((i * 5 + k * 3 + seed * 7) % 16);
    return v;
  endfunction

  task automatic idle();
    in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0;
  endtask

  task automatic send_frame(input int m, input int seed, input bit gaps);
    for (int i = 0; i < m; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b1; in_end = 1'b1; in_data = '1;
      end
      @(negedge clk);
      in_valid = 1'b1; in_start = (i == 0); in_end = (i == m - 1); in_data = smp(seed, i);
    end
    @(negedge clk);
    idle();
  endtask

  // entered at the first negedge after the end edge
  task automatic run_replay(input int m, input int seed, input bit inject);
    chk(busy == 1'b1, "R6", busy, 1);
    chk(out_valid == 1'b0, "R5", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R5", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1 && out_step == 0, (m == MAX_LEN) ? "R10" : "R5", out_valid, 1);
    for (int s = 0; s < m + 80; s++) begin
      int idx = (s < m) ? s : (s - m) % m;
      chk(out_valid && out_data == smp(seed, idx), (s < m) ? "R1" : "R2", out_data, smp(seed, idx));
      chk(out_step == STW'(s), "R3", out_step, s);
      chk(out_train == (s >= m), (s < m) ? "R1" : "R2", out_train, s >= m);
      chk(out_last == (s == m + 79), "R4", out_last, s == m + 79);
      chk(busy == (s != m + 79), "R6", busy, s != m + 79);
      if (inject && s == 2) begin
        in_valid = 1'b1; in_start = 1'b1; in_end = 1'b1; in_data = '1;
      end
      if (inject && s == 3) begin
        chk(err_start == 1'b1, "R7", err_start, 1);
        idle();
      end
      @(negedge clk);
    end
    chk(out_valid == 1'b0, "R4", out_valid, 0);
    if (inject) begin
      int seen = 0;
      repeat (8) begin
        @(negedge clk);
        if (out_valid || busy) seen++;
      end
      chk(seen == 0, "R7", seen, 0);
    end
  endtask

  task automatic watch_quiet(input int cycles, input string req);
    int seen = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (out_valid || busy) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({out_valid, out_last, busy, err_len, err_start} == 5'b0, "R12",
        {out_valid, out_last, busy, err_len, err_start}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({out_valid, out_last, busy, err_len, err_start} == 5'b0, "R12",
        {out_valid, out_last, busy, err_len, err_start}, 0);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      send_frame(VEC[v][0], VEC[v][1], VEC[v][2] != 0);
      run_replay(VEC[v][0], VEC[v][1], 1'b0);
    end

    // R7: start during replay
    send_frame(6, 9, 1'b0);
    run_replay(6, 9, 1'b1);

    // R9: valid samples with no frame open
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_start = 1'b0; in_end = (i == 4); in_data = smp(30, i);
    end
    @(negedge clk);
    idle();
    watch_quiet(10, "R9");

    // R11: partial frame restarted
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_start = (i == 0); in_end = 1'b0; in_data = smp(20, i);
    end
    send_frame(7, 11, 1'b1);
    run_replay(7, 11, 1'b0);

    // R8: overlong frame
    for (int i = 0; i <= MAX_LEN; i++) begin
      @(negedge clk);
      if (i == MAX_LEN) chk(err_len == 1'b0, "R8", err_len, 0);
      in_valid = 1'b1; in_start = (i == 0); in_end = (i == MAX_LEN); in_data = smp(40, i);
    end
    @(negedge clk);
    chk(err_len == 1'b1, "R8", err_len, 1);
    idle();
    @(negedge clk);
    chk(err_len == 1'b0, "R8", err_len, 0);
    watch_quiet(200, "R8");
    send_frame(9, 8, 1'b0);
    run_replay(9, 8, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule